// File: doc/BRIEF.md
# Flash Interrupt and Status Controller

This block holds the command register, the interrupt-status register, the controller-status (error) register and two system-configuration registers of a flash memory interface. It also drives the interrupt and ready pins. A host reaches the registers through a simple single-cycle register port. A separate command executor reports its results through pulse inputs: a completion event carries the kind of operation and an error flag, and a separate pulse reports a command code it did not recognise.

Completion events set a per-operation bit and a master bit in the interrupt-status register. Errors set bits in the controller-status register. The host acknowledges events by writing a mask to the interrupt-status register, and the mask is ANDed with the current contents. New command writes are refused while the master bit is set, so the host must acknowledge before it issues the next command. The polarity of the interrupt pin comes from a configuration bit.

There are two resets. A cold reset (`rst_n` low) and a warm reset (a `warm_rst` pulse) both load defined register values. They differ only in the completion bit that they leave set.

All pins are plain control and status signals. There is no stream interface and no back-pressure. A register write takes effect on the clock edge where `reg_wr` is high. A read returns the addressed register combinationally. Register addresses are: 0 command, 1 configuration 1, 2 configuration 2, 3 controller status, 4 interrupt status. Addresses 5 to 7 read as zero and ignore writes.

Top module: `flash_irq_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, the registers read as follows: interrupt status 0x8080, controller status 0x0000, configuration 1 0x40C0, configuration 2 0x0000, command 0x0000. Both `irq` and `rdy` are high.
- R2: A cycle with `warm_rst` high loads the following values on that edge: interrupt status 0x8010, controller status 0, configuration 1 0x40C0, configuration 2 0, command 0, with `irq` and `rdy` high.
- R3: A cycle with `ev_done` high sets interrupt-status bit 15 (master) and bit 4+`ev_kind` on that edge. The kind codes are 0 reset, 1 erase, 2 program, 3 load, which set bits 4, 5, 6 and 7.
- R4: `ev_done` with `ev_err` sets controller-status bit 10 (command error). For kinds 1, 2 and 3 it also sets bit 10+`ev_kind` (11 erase, 12 program, 13 load). An `ev_unknown` pulse sets status bit 10 and interrupt bit 15.
- R5: A write to interrupt status replaces it with the bitwise AND of its current value and the written data.
- R6: When interrupt bit 15 is clear after an update, controller-status bits 10 to 13 are cleared. While bit 15 stays set, those bits are kept.
- R7: `irq` is registered and equals interrupt bit 15 XOR NOT configuration-1 bit 6. It is active-high when bit 6 is 1 and active-low when bit 6 is 0.
- R8: A command write while interrupt bit 15 is set is ignored: the command readback keeps its old value and `cmd_issue` stays low.
- R9: An accepted command write stores the data as the command readback and pulses `cmd_issue` for exactly one cycle after the edge, with `cmd_code` holding the data.
- R10: A write to configuration 1 sets `rdy` to bit 7 of the written data on that edge.
- R11: Configuration 1 reads back with its low five bits forced to zero. Configuration 2 reads back exactly as written. Unmapped addresses read zero.
- R12: A warm reset takes priority over any completion event or register write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Cold reset, active low, synchronous |
| warm_rst | input | 1 | Warm reset pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| ev_done | input | 1 | Executor completion pulse |
| ev_kind | input | 2 | Operation kind for `ev_done` |
| ev_err | input | 1 | Completion ended with an error |
| ev_unknown | input | 1 | Executor saw an unrecognised command |
| cmd_issue | output | 1 | One-cycle pulse for an accepted command |
| cmd_code | output | 16 | Code of the accepted command |
| irq | output | 1 | Interrupt pin, polarity set by configuration |
| rdy | output | 1 | Ready pin |

## Verification
The assertions check the following on every cycle:
- the interrupt pin agrees with the master bit and the polarity bit;
- an error bit is never present without the master bit;
- a completion always leaves the master bit set;
- a blocked command write neither changes the command nor issues it;
- the ready pin takes the written bit 7;
- a warm reset loads its values.

Some behaviour can only be shown by the bench's scenarios:
- which type bit and which error bits each operation kind produces;
- the AND-mask acknowledge arithmetic;
- the configuration-1 readback masking;
- the priority of a warm reset over a simultaneous event and write.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int DW          = 16;
  localparam int CMD_W       = 16;
  localparam int AW          = 3;
  localparam int MASTER_BIT  = 15;
  localparam int DONE_LSB    = 4;
  localparam int ERR_LSB     = 10;
  localparam int POL_BIT     = 6;
  localparam int RDY_BIT     = 7;
  localparam int CFG1_RD_LSB = 5;

  localparam logic [DW-1:0] INT_COLD  = 16'h8080;
  localparam logic [DW-1:0] INT_WARM  = 16'h8010;
  localparam logic [DW-1:0] CFG1_INIT = 16'h40C0;
  localparam logic [DW-1:0] ERR_MASK  = 16'h3C00;

  typedef enum logic [AW-1:0] {
    RA_CMD  = 3'd0,
    RA_CFG1 = 3'd1,
    RA_CFG2 = 3'd2,
    RA_STAT = 3'd3,
    RA_INT  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_RESET = 2'd0,
    OP_ERASE = 2'd1,
    OP_PROG  = 2'd2,
    OP_LOAD  = 2'd3
  } op_kind_e;
endpackage

// File: rtl/fic_intstat.sv
module fic_intstat
  import fic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst,
  input  logic          int_wr,
  input  logic [DW-1:0] wdata,
  input  logic          ev_done,
  input  logic [1:0]    ev_kind,
  input  logic          ev_err,
  input  logic          ev_unknown,
  output logic [DW-1:0] int_q,
  output logic [DW-1:0] stat_q,
  output logic          master_nxt
);
  logic [DW-1:0] int_n, stat_n, done_vec, err_vec;

  always_comb begin
    done_vec = '0;
    err_vec  = '0;
    if (ev_done) begin
      done_vec[MASTER_BIT] = 1'b1;
      done_vec[DONE_LSB+3:DONE_LSB] = 4'b0001 << ev_kind;
      if (ev_err) begin
        err_vec[ERR_LSB]   = 1'b1;
        err_vec[ERR_LSB+1] = (ev_kind == OP_ERASE);
        err_vec[ERR_LSB+2] = (ev_kind == OP_PROG);
        err_vec[ERR_LSB+3] = (ev_kind == OP_LOAD);
      end
    end
    if (ev_unknown) begin
      done_vec[MASTER_BIT] = 1'b1;
      err_vec[ERR_LSB]     = 1'b1;
    end
  end

  always_comb begin
    int_n = int_wr ? (int_q & wdata) : int_q;
    int_n = int_n | done_vec;
    stat_n = int_n[MASTER_BIT] ? ((stat_q | err_vec) & ERR_MASK) : '0;
  end

  assign master_nxt = (!rst_n || warm_rst) ? 1'b1 : int_n[MASTER_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q  <= INT_COLD;
      stat_q <= '0;
    end else if (warm_rst) begin
      int_q  <= INT_WARM;
      stat_q <= '0;
    end else begin
      int_q  <= int_n;
      stat_q <= stat_n;
    end
  end

  // R6: error bits exist only while the master bit is set
  a_r6_err_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0) |-> int_q[MASTER_BIT]);

  // R3: a completion leaves the master bit set
  a_r3_done_sets_master: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_done && !warm_rst) |=> int_q[MASTER_BIT]);

  // R2: warm reset values
  a_r2_warm_values: assert property (@(posedge clk) disable iff (!rst_n)
    warm_rst |=> (int_q == INT_WARM) && (stat_q == '0));
endmodule

// File: rtl/fic_cfg.sv
module fic_cfg
  import fic_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          warm_rst,
  input  logic          cfg1_wr,
  input  logic          cfg2_wr,
  input  logic [DW-1:0] wdata,
  input  logic          master_nxt,
  output logic [DW-1:0] cfg1_q,
  output logic [DW-1:0] cfg2_q,
  output logic          rdy_q,
  output logic          irq_q
);
  logic [DW-1:0] cfg1_n;

  always_comb begin
    if (!rst_n || warm_rst) cfg1_n = CFG1_INIT;
    else if (cfg1_wr)       cfg1_n = wdata;
    else                    cfg1_n = cfg1_q;
  end

  always_ff @(posedge clk) begin
    cfg1_q <= cfg1_n;
    irq_q  <= master_nxt ^ ~cfg1_n[POL_BIT];
    if (!rst_n || warm_rst) begin
      cfg2_q <= '0;
      rdy_q  <= 1'b1;
    end else begin
      if (cfg2_wr) cfg2_q <= wdata;
      if (cfg1_wr) rdy_q  <= wdata[RDY_BIT];
    end
  end

  // R10: ready pin takes bit 7 of a configuration-1 write
  a_r10_rdy_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_wr && !warm_rst) |=> (rdy_q == $past(wdata[RDY_BIT])));
endmodule

// File: rtl/fic_cmd.sv
module fic_cmd
  import fic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] wdata,
  input  logic             master_q,
  output logic [CMD_W-1:0] cmd_q,
  output logic             issue_q
);
  logic accept;
  assign accept = cmd_wr && !master_q;

  always_ff @(posedge clk) begin
    if (!rst_n || warm_rst) begin
      cmd_q   <= '0;
      issue_q <= 1'b0;
    end else begin
      issue_q <= accept;
      if (accept) cmd_q <= wdata;
    end
  end

  // R8: a command write during a pending interrupt changes nothing
  a_r8_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && master_q && !warm_rst) |=> ($stable(cmd_q) && !issue_q));
endmodule

// File: rtl/flash_irq_ctrl.sv
module flash_irq_ctrl
  import fic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             warm_rst,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             ev_done,
  input  logic [1:0]       ev_kind,
  input  logic             ev_err,
  input  logic             ev_unknown,
  output logic             cmd_issue,
  output logic [CMD_W-1:0] cmd_code,
  output logic             irq,
  output logic             rdy
);
  logic [DW-1:0] int_q, stat_q, cfg1_q, cfg2_q;
  logic          master_nxt;

  logic wr_cmd, wr_cfg1, wr_cfg2, wr_int;
  assign wr_cmd  = reg_wr && (reg_addr == RA_CMD);
  assign wr_cfg1 = reg_wr && (reg_addr == RA_CFG1);
  assign wr_cfg2 = reg_wr && (reg_addr == RA_CFG2);
  assign wr_int  = reg_wr && (reg_addr == RA_INT);

  fic_intstat u_int (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .int_wr(wr_int),
    .wdata(reg_wdata), .ev_done(ev_done), .ev_kind(ev_kind), .ev_err(ev_err),
    .ev_unknown(ev_unknown), .int_q(int_q), .stat_q(stat_q),
    .master_nxt(master_nxt)
  );

  fic_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .cfg1_wr(wr_cfg1),
    .cfg2_wr(wr_cfg2), .wdata(reg_wdata), .master_nxt(master_nxt),
    .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .rdy_q(rdy), .irq_q(irq)
  );

  fic_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .cmd_wr(wr_cmd),
    .wdata(reg_wdata), .master_q(int_q[MASTER_BIT]), .cmd_q(cmd_code),
    .issue_q(cmd_issue)
  );

  always_comb begin
    case (reg_addr)
      RA_CMD:  reg_rdata = cmd_code;
      RA_CFG1: reg_rdata = {cfg1_q[DW-1:CFG1_RD_LSB], {CFG1_RD_LSB{1'b0}}};
      RA_CFG2: reg_rdata = cfg2_q;
      RA_STAT: reg_rdata = stat_q;
      RA_INT:  reg_rdata = int_q;
      default: reg_rdata = '0;
    endcase
  end

  // R7: interrupt pin polarity relation between status and configuration
  a_r7_irq_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (int_q[MASTER_BIT] ^ ~cfg1_q[POL_BIT]));
endmodule

// File: tb/flash_irq_ctrl_tb.sv
module flash_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, warm_rst = 1'b0, reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic ev_done = 1'b0, ev_err = 1'b0, ev_unknown = 1'b0;
  logic [1:0] ev_kind = '0;
  logic cmd_issue, irq, rdy;
  logic [15:0] cmd_code;
  int checks = 0, fails = 0;
  logic [15:0] d, exp_int, exp_stat;

  always #5 clk = ~clk;

  flash_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_done(ev_done), .ev_kind(ev_kind), .ev_err(ev_err),
    .ev_unknown(ev_unknown), .cmd_issue(cmd_issue), .cmd_code(cmd_code),
    .irq(irq), .rdy(rdy)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] v);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic ev(input logic [1:0] k, input logic e);
    @(negedge clk); ev_done = 1'b1; ev_kind = k; ev_err = e;
    @(negedge clk); ev_done = 1'b0; ev_err = 1'b0;
  endtask

  task automatic unk();
    @(negedge clk); ev_unknown = 1'b1;
    @(negedge clk); ev_unknown = 1'b0;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 cold reset state
    rd(4, d); chk("R1 int", d, 16'h8080);
    rd(3, d); chk("R1 stat", d, 16'h0000);
    rd(1, d); chk("R1 cfg1", d, 16'h40C0);
    rd(2, d); chk("R1 cfg2", d, 16'h0000);
    rd(0, d); chk("R1 cmd", d, 16'h0000);
    chk("R1 irq", {15'b0, irq}, 16'd1);
    chk("R1 rdy", {15'b0, rdy}, 16'd1);

    wr(4, 16'h0000);
    rd(4, d); chk("R5 int cleared", d, 16'h0000);
    chk("R7 irq idle", {15'b0, irq}, 16'd0);

    wr(0, 16'h00AB);
    chk("R9 issue", {15'b0, cmd_issue}, 16'd1);
    chk("R9 code", cmd_code, 16'h00AB);
    @(negedge clk);
    chk("R9 single pulse", {15'b0, cmd_issue}, 16'd0);
    rd(0, d); chk("R9 cmd readback", d, 16'h00AB);

    for (int k = 0; k < 4; k++) begin
      for (int e = 0; e < 2; e++) begin
        ev(k[1:0], e[0]);
        exp_int  = 16'h8000 | (16'd1 << (4 + k));
        exp_stat = (e == 1) ? (16'h0400 | ((k != 0) ? (16'd1 << (10 + k)) : 16'h0)) : 16'h0;
        rd(4, d); chk("R3 done bits", d, exp_int);
        rd(3, d); chk("R4 error bits", d, exp_stat);
        chk("R7 irq pending", {15'b0, irq}, 16'd1);
        wr(0, 16'h0055);
        chk("R8 blocked issue", {15'b0, cmd_issue}, 16'd0);
        rd(0, d); chk("R8 blocked cmd", d, 16'h00AB);
        wr(4, 16'h7FFF);
        exp_int = exp_int & 16'h7FFF;
        rd(4, d); chk("R5 and mask", d, exp_int);
        rd(3, d); chk("R6 errors cleared", d, 16'h0000);
        wr(4, 16'h0000);
      end
    end

    ev(2'd3, 1'b1);
    wr(4, 16'h80FF);
    rd(4, d); chk("R5 keep master", d, 16'h8080);
    rd(3, d); chk("R6 errors kept", d, 16'h2400);
    wr(4, 16'hFF7F);
    rd(4, d); chk("R5 drop load bit", d, 16'h8000);
    rd(3, d); chk("R6 still kept", d, 16'h2400);
    wr(4, 16'h0000);
    rd(3, d); chk("R6 cleared at end", d, 16'h0000);

    unk();
    rd(4, d); chk("R4 unknown int", d, 16'h8000);
    rd(3, d); chk("R4 unknown stat", d, 16'h0400);
    wr(4, 16'h0000);

    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 2; p++) begin
        if (m == 1) unk(); else wr(4, 16'h0000);
        wr(1, 16'h001F | (16'(p) << 6) | (16'(m) << 7));
        chk("R7 irq polarity", {15'b0, irq}, {15'b0, m[0] ^ ~p[0]});
        chk("R10 rdy", {15'b0, rdy}, {15'b0, m[0]});
        rd(1, d); chk("R11 cfg1 mask", d, (16'(p) << 6) | (16'(m) << 7));
      end
    end
    wr(4, 16'h0000);

    wr(1, 16'hFFFF); rd(1, d); chk("R11 cfg1 all", d, 16'hFFE0);
    wr(2, 16'h1234); rd(2, d); chk("R11 cfg2", d, 16'h1234);
    rd(7, d); chk("R11 unmapped", d, 16'h0000);
    wr(1, 16'h0000);

    // R2 and R12: warm reset with a simultaneous event and write
    @(negedge clk);
    warm_rst = 1'b1; ev_done = 1'b1; ev_kind = 2'd2; ev_err = 1'b1;
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 16'hBEEF;
    @(negedge clk);
    warm_rst = 1'b0; ev_done = 1'b0; ev_err = 1'b0; reg_wr = 1'b0;
    rd(4, d); chk("R2 R12 int", d, 16'h8010);
    rd(3, d); chk("R2 R12 stat", d, 16'h0000);
    rd(1, d); chk("R2 cfg1", d, 16'h40C0);
    rd(2, d); chk("R12 cfg2", d, 16'h0000);
    rd(0, d); chk("R2 cmd", d, 16'h0000);
    chk("R2 irq", {15'b0, irq}, 16'd1);
    chk("R2 rdy", {15'b0, rdy}, 16'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule